// File: doc/BRIEF.md
# CAN Overload Frame Trigger Detector

This block sits beside the bit-level state machine of a CAN protocol controller. On every bit-sample strobe it looks at the sampled bus level together with two pieces of framing context: the field the controller is in and the bit index within that field. A dominant level at one of a small set of positions means that the node must start an overload frame. When that happens, the block raises a one-clock request.

There are four trigger slots:
- the first two bits of intermission;
- the last bit of end of frame, but only when this node is receiving the frame;
- the last bit of an error delimiter;
- the last bit of an overload delimiter.

The bus level input uses logic 0 for dominant and logic 1 for recessive. The bit index is zero-based, so the first bit of a field has index 0.

The field code is a 3-bit value:

| Code | Field |
|---|---|
| 0 | any other field |
| 1 | bus idle |
| 2 | intermission |
| 3 | end of frame |
| 4 | error delimiter |
| 5 | overload delimiter |

Codes 6 and 7 behave like code 0. Building the overload flag itself and counting overload frames are left to other logic.

Top module: `ovld_trigger_det`

## Requirements
- R1: While `rst` is high at a rising clock edge, `ovld_req` is 0 in the following cycle, whatever the other inputs are.
- R2: A strobe with `bus_lvl`=0, field code 2 and `bit_idx` of 0 or 1 sets `ovld_req` to 1 for the cycle after that strobe's clock edge.
- R3: A strobe with `bus_lvl`=0, field code 2 and `bit_idx` of 2 or higher gives `ovld_req`=0 in the next cycle.
- R4: A strobe with `bus_lvl`=0, field code 3 and `bit_idx`=6 gives `ovld_req`=1 in the next cycle when `rx_role`=1, and 0 when `rx_role`=0.
- R5: A strobe with `bus_lvl`=0, field code 4 and `bit_idx`=7 gives `ovld_req`=1 in the next cycle.
- R6: A strobe with `bus_lvl`=0, field code 5 and `bit_idx`=7 gives `ovld_req`=1 in the next cycle.
- R7: A recessive sample (`bus_lvl`=1), or any combination of field code and bit index not named in R2, R4, R5 or R6, gives `ovld_req`=0 in the next cycle. This includes bus idle (code 1) and codes 0, 6 and 7.
- R8: A cycle with `smp_stb`=0 gives `ovld_req`=0 in the next cycle. Each request therefore lasts exactly one clock per detecting strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-clock strobe marking a valid bus sample |
| bus_lvl | input | 1 | Sampled bus level (0 dominant, 1 recessive) |
| field | input | 3 | Current frame field code |
| bit_idx | input | CNT_W | Zero-based bit index within the field |
| rx_role | input | 1 | 1 when this node is the receiver of the current frame |
| ovld_req | output | 1 | One-clock overload start request |

## Verification
Every result is due exactly one clock after the rising edge that sampled the inputs, because a single register lies between the inputs and `ovld_req`. The bench drives inputs on falling edges. Its behavioural model computes the expected output at the same rising edge that the design samples, and the comparison is made on the next falling edge, so each expectation lines up with the one register stage. Directed vectors cover each trigger slot, the neighbouring non-trigger slots and both receiver roles. An exhaustive sweep over every field code, bit index, level, role and strobe value then follows.

// File: rtl/ovld_pkg.sv
package ovld_pkg;

    typedef enum logic [2:0] {
        FLD_OTHER  = 3'd0,
        FLD_IDLE   = 3'd1,
        FLD_INTERM = 3'd2,
        FLD_EOF    = 3'd3,
        FLD_ERRDLM = 3'd4,
        FLD_OVLDLM = 3'd5
    } field_e;

    // level encoding on the sampled bus
    localparam logic LVL_DOMINANT = 1'b0;

    function automatic logic is_dominant(input logic lvl);
        return lvl == LVL_DOMINANT;
    endfunction

    typedef struct packed {
        logic   stb;
        logic   dom;
        logic   hit;
    } sample_t;

endpackage

// File: rtl/ovld_slot_decode.sv
module ovld_slot_decode
    import ovld_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int IFS_TRIG_N = 2,
    parameter int EOF_LEN    = 7,
    parameter int DLM_LEN    = 8
) (
    input  logic [2:0]       field,
    input  logic [CNT_W-1:0] bit_idx,
    input  logic             rx_role,
    output logic             slot_hit
);
    localparam logic [CNT_W-1:0] EOF_LAST = CNT_W'(EOF_LEN - 1);
    localparam logic [CNT_W-1:0] DLM_LAST = CNT_W'(DLM_LEN - 1);

    logic [IFS_TRIG_N-1:0] ifs_match;

    generate
        for (genvar g = 0; g < IFS_TRIG_N; g++) begin : g_ifs
            assign ifs_match[g] = (bit_idx == CNT_W'(g));
        end
    endgenerate

    always_comb begin
        slot_hit = 1'b0;
        case (field)
            FLD_INTERM: slot_hit = |ifs_match;
            FLD_EOF:    slot_hit = rx_role && (bit_idx == EOF_LAST);
            FLD_ERRDLM: slot_hit = (bit_idx == DLM_LAST);
            FLD_OVLDLM: slot_hit = (bit_idx == DLM_LAST);
            default:    slot_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ovld_pulse_gen.sv
module ovld_pulse_gen
    import ovld_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sample_t smp,
    output logic    req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
        end else begin
            req <= smp.stb && smp.dom && smp.hit;
        end
    end
endmodule

// File: rtl/ovld_trigger_det.sv
module ovld_trigger_det
    import ovld_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int IFS_TRIG_N = 2,
    parameter int EOF_LEN    = 7,
    parameter int DLM_LEN    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_stb,
    input  logic             bus_lvl,
    input  logic [2:0]       field,
    input  logic [CNT_W-1:0] bit_idx,
    input  logic             rx_role,
    output logic             ovld_req
);
    logic    slot_hit;
    sample_t smp;

    ovld_slot_decode #(
        .CNT_W(CNT_W), .IFS_TRIG_N(IFS_TRIG_N),
        .EOF_LEN(EOF_LEN), .DLM_LEN(DLM_LEN)
    ) dec_i (
        .field(field), .bit_idx(bit_idx), .rx_role(rx_role), .slot_hit(slot_hit)
    );

    assign smp = '{stb: smp_stb, dom: is_dominant(bus_lvl), hit: slot_hit};

    ovld_pulse_gen pg_i (.clk(clk), .rst(rst), .smp(smp), .req(ovld_req));
endmodule

// File: rtl/ovld_trigger_chk.sv
module ovld_trigger_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_stb,
    input logic             bus_lvl,
    input logic [2:0]       field,
    input logic [CNT_W-1:0] bit_idx,
    input logic             rx_role,
    input logic             ovld_req
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !ovld_req);
    // R2
    interm_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !bus_lvl && field == 3'd2 && bit_idx < CNT_W'(2)) |=> ovld_req);
    // R3
    interm_late_chk: assert property (@(posedge clk) disable iff (rst)
        (field == 3'd2 && bit_idx >= CNT_W'(2)) |=> !ovld_req);
    // R4
    eof_rx_only_chk: assert property (@(posedge clk) disable iff (rst)
        (field == 3'd3 && !rx_role) |=> !ovld_req);
    // R5
    errdlm_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !bus_lvl && field == 3'd4 && bit_idx == CNT_W'(7)) |=> ovld_req);
    // R6
    ovldlm_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !bus_lvl && field == 3'd5 && bit_idx == CNT_W'(7)) |=> ovld_req);
    // R7
    recessive_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        bus_lvl |=> !ovld_req);
    // R8
    no_strobe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> !ovld_req);
endmodule

bind ovld_trigger_det ovld_trigger_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .bus_lvl(bus_lvl),
    .field(field), .bit_idx(bit_idx), .rx_role(rx_role), .ovld_req(ovld_req)
);

// File: tb/ovld_trigger_det_tb.sv
`timescale 1ns/1ps
module ovld_trigger_det_tb_top;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             smp_stb = 1'b0;
    logic             bus_lvl = 1'b1;
    logic [2:0]       field = 3'd0;
    logic [CNT_W-1:0] bit_idx = '0;
    logic             rx_role = 1'b0;
    logic             ovld_req;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    exp_req = 1'b0;
    bit    exp_valid = 1'b0;
    string cur_tag = "R1";
    string exp_tag = "R1";

    always #10 clk = ~clk;

    ovld_trigger_det #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .bus_lvl(bus_lvl),
        .field(field), .bit_idx(bit_idx), .rx_role(rx_role), .ovld_req(ovld_req)
    );

    function automatic bit model(bit s, bit lvl, int f, int idx, bit rx);
        if (!s || lvl) return 1'b0;
        if (f == 2) return idx == 0 || idx == 1;
        if (f == 3) return rx && idx == 6;
        if (f == 4 || f == 5) return idx == 7;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        exp_valid <= 1'b1;
        exp_tag <= cur_tag;
        if (rst) exp_req <= 1'b0;
        else exp_req <= model(smp_stb, bus_lvl, int'(field), int'(bit_idx), rx_role);
    end

    always @(negedge clk) begin
        if (exp_valid) begin
            n_vec++;
            if (ovld_req !== exp_req) begin
                n_bad++;
                $display("FAIL %s: ovld_req=%0b expected %0b (cycle %0d)",
                         exp_tag, ovld_req, exp_req, cyc);
            end
        end
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic drive(input string tag, input bit s, input bit lvl,
                         input int f, input int idx, input bit rx);
        @(negedge clk);
        cur_tag = tag;
        smp_stb = s; bus_lvl = lvl; field = 3'(f); bit_idx = CNT_W'(idx); rx_role = rx;
    endtask

    initial begin
        // R1: reset held with a trigger pattern present
        drive("R1", 1, 0, 2, 0, 1);
        drive("R1", 1, 0, 5, 7, 1);
        drive("R1", 1, 0, 4, 7, 0);
        @(negedge clk);
        rst = 1'b0;
        drive("R2", 1, 0, 2, 0, 0);
        drive("R8", 0, 0, 2, 0, 0);
        drive("R2", 1, 0, 2, 1, 1);
        drive("R2", 1, 0, 2, 0, 0);
        drive("R2", 1, 0, 2, 1, 0);
        drive("R3", 1, 0, 2, 2, 1);
        drive("R3", 1, 0, 2, 3, 0);
        drive("R4", 1, 0, 3, 6, 1);
        drive("R4", 1, 0, 3, 6, 0);
        drive("R4", 1, 0, 3, 5, 1);
        drive("R5", 1, 0, 4, 7, 0);
        drive("R5", 1, 0, 4, 6, 0);
        drive("R6", 1, 0, 5, 7, 1);
        drive("R6", 1, 0, 5, 6, 1);
        drive("R7", 1, 1, 2, 0, 1);
        drive("R7", 1, 1, 4, 7, 1);
        drive("R7", 1, 0, 1, 0, 1);
        drive("R7", 1, 0, 0, 7, 1);
        drive("R8", 0, 0, 5, 7, 1);
        drive("R8", 0, 0, 3, 6, 1);
        // R1: reset asserted mid-stream
        rst = 1'b1;
        drive("R1", 1, 0, 4, 7, 1);
        rst = 1'b0;
        // R7 exhaustive sweep over every input combination
        for (int f = 0; f < 8; f++)
            for (int i = 0; i < 16; i++)
                for (int v = 0; v < 8; v++)
                    drive("R7", v[0], v[1], f, i, v[2]);
        drive("R8", 0, 1, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule